// File: doc/BRIEF.md
# Pipelined Converter Digital Error Correction

This block forms the final 10-bit result of a pipelined analog-to-digital converter that resolves 1.5 bits per stage. Eight residue stages each deliver a 2-bit coarse code, and a closing flash stage delivers one more 2-bit code. Together these are nine codes per sample. The stages work in a staggered fashion, so the codes belonging to one sample arrive over several clock cycles. Stages are paired: stage 1 and stage 2 report in the same cycle, stages 3 and 4 report one cycle later, and so on, until stage 9 reports four cycles after stage 1.

Each stage code passes through its own alignment delay line. The earliest stage gets the longest line and the final flash stage gets the shortest, so that the nine codes of a sample reach the correction adder in the same cycle. The adder does not concatenate the codes. It overlap-adds them, because adjacent stages share one bit of weight, and this redundancy absorbs comparator offsets in the analog stages. The sum is saturated to 10 bits and captured on the falling clock edge in offset-binary form.

A power-enable input gates conversion. A valid flag stays low until the converter has been enabled long enough to settle and for the pipeline to fill. One new result leaves the block every clock.

Top module: `pipe_adc_corr`

## Requirements
- R1: The stage j code of a sample (j = 1..9) is presented on `stageCodes` floor((j-1)/2) cycles after that sample's stage 1 code. The corrected word for that sample appears at the falling clock edge 5 cycles after the rising edge that follows the stage 1 code. Consecutive samples give consecutive results, one per cycle.
- R2: Stage j, for j = 1..8, occupies bits [2j-1:2j-2] of `stageCodes`. Its code contributes d_j * 2^(9-j) to the result. A lone residue code of 1 in stage j gives 2^(9-j).
- R3: The output is offset binary. All residue codes at 1 with a flash code of 2 give 0x200. All codes at 0 give 0x000. A full-scale positive input gives 0x3FF.
- R4: A residue stage code of 3 is illegal and is treated as 2. For example, stage 1 at 3 with all other codes at 0 gives 0x200, not 0x300.
- R5: The flash stage code occupies bits [17:16] and is added at weight 1. All four of its values 0 to 3 are honoured.
- R6: The result saturates at 0x3FF. All nine codes at 3 give 0x3FF.
- R7: For any input level in the converter's range, the output equals floor((x + 1) * 512) clamped to 0x3FF. Here x is the normalised differential input in [-1, 1) and the stage codes come from a 1.5-bit pipeline with decision levels at plus and minus one quarter.
- R8: `dataValid` rises at the falling edge that follows the 20th consecutive rising edge at which `powerEn` is sampled high. It is low before that edge.
- R9: At the falling edge after a rising edge at which `powerEn` is sampled low, `dataValid` drops low and `dataOut` reads 0x000. Re-enabling restarts the full 20-cycle count.
- R10: While `rstN` is low, `dataOut` is 0x000 and `dataValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; alignment lines shift on the rising edge, the output register loads on the falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| powerEn | input | 1 | Conversion enable; low means powered down |
| stageCodes | input | 18 | Nine 2-bit stage codes, stage j at bits [2j-1:2j-2] |
| dataOut | output | 10 | Corrected offset-binary result |
| dataValid | output | 1 | High when `dataOut` carries a settled conversion result |

## Verification
A stream of input levels is converted by a behavioural 1.5-bit pipeline model and fed to the block with the stagger applied. This stream shows whether per-stage alignment is right: a line that is one cycle too short or too long mixes codes from neighbouring samples. Levels at exactly plus and minus one quarter, and one LSB on either side of them, exercise the redundant decision points where adjacent stages overlap. Constant single-stage patterns isolate each weight, the illegal-code clamp and the flash weight. An isolated full-scale sample in a zero stream pins the latency to exactly five cycles. Power-enable toggling checks the valid count, the restart of that count, and the cleared output.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

  // Number of coarse stages (eight residue stages plus one final flash)
  localparam int NUM_STAGES = 9;
  // Width of one stage code
  localparam int CODE_W = 2;
  // Width of the corrected output word
  localparam int OUT_W = NUM_STAGES + 1;
  // Rising edges from the first stage code to the output capture
  localparam int LATENCY = 5;
  // Stages that report in the same cycle
  localparam int STAGES_PER_STEP = 2;
  // Enabled cycles before the output may be trusted
  localparam int WARMUP_CYC = 20;

  // Derived
  localparam int SUM_W = OUT_W + 1;
  localparam int READY_LIMIT = (WARMUP_CYC > LATENCY) ? WARMUP_CYC : LATENCY;
  localparam int CNT_W = $clog2(READY_LIMIT + 1);
  localparam int BUS_W = NUM_STAGES * CODE_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // advance the alignment lines
    logic outLoad;   // capture the corrected word on the falling edge
    logic outClear;  // force the output word to zero
  } corrStrobes_t;

  // Alignment depth for stage index j (0-based): earlier stages wait longer
  function automatic int alignDepth(int j);
    return LATENCY - (j / STAGES_PER_STEP);
  endfunction

  // Weight shift for stage index j (0-based); the flash stage lands at 2^0
  function automatic int stageShift(int j);
    return NUM_STAGES - 1 - j;
  endfunction

endpackage

// File: rtl/corr_delay_line.sv
module corr_delay_line #(
  parameter int DEPTH = 1,
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         shiftEn,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] tap [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) tap[k] <= '0;
    end else if (shiftEn) begin
      tap[0] <= din;
      for (int k = 1; k < DEPTH; k++) tap[k] <= tap[k-1];
    end
  end

  assign dout = tap[DEPTH-1];

endmodule

// File: rtl/corr_ctrl.sv
module corr_ctrl
  import adc_corr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         powerEn,
  output corrStrobes_t strobes,
  output logic         validOut
);

  logic [CNT_W-1:0] upCnt;
  logic             isReady;

  // Enabled-cycle counter, restarts on every power-down
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upCnt <= '0;
    end else if (!powerEn) begin
      upCnt <= '0;
    end else if (upCnt != CNT_W'(READY_LIMIT)) begin
      upCnt <= upCnt + 1'b1;
    end
  end

  assign isReady = (upCnt == CNT_W'(READY_LIMIT));

  always_comb begin
    strobes.shiftEn  = powerEn;
    strobes.outLoad  = (upCnt != '0);
    strobes.outClear = (upCnt == '0);
  end

  // Valid flag moves with the data word on the falling edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= isReady;
  end

  // R9
  powered_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt != '0) |-> $past(powerEn));

  // R9
  down_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !powerEn |=> !validOut);

  // R8
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validOut) |-> (upCnt == CNT_W'(READY_LIMIT)) &&
                        ($past(upCnt) == CNT_W'(READY_LIMIT - 1)));

  // R10
  always @(posedge clk) begin
    if (!rstN) reset_valid_chk: assert (!validOut);
  end

endmodule

// File: rtl/corr_datapath.sv
module corr_datapath
  import adc_corr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  corrStrobes_t     strobes,
  input  logic [BUS_W-1:0] stageCodes,
  output logic [OUT_W-1:0] dataOut
);

  localparam logic [CODE_W-1:0] ILLEGAL_CODE = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] RESIDUE_MAX  = CODE_W'(2);
  localparam logic [SUM_W-1:0]  OUT_MAX      = SUM_W'((1 << OUT_W) - 1);

  logic [CODE_W-1:0] cleanCode   [NUM_STAGES];
  logic [CODE_W-1:0] alignedCode [NUM_STAGES];
  logic [SUM_W-1:0]  sumAcc;
  logic [OUT_W-1:0]  dataNext;

  for (genvar j = 0; j < NUM_STAGES; j++) begin : g_stage
    logic [CODE_W-1:0] rawCode;
    assign rawCode = stageCodes[j*CODE_W +: CODE_W];

    if (j < NUM_STAGES - 1) begin : g_residue
      // 1.5-bit stage: only 0, 1, 2 are legal
      assign cleanCode[j] = (rawCode == ILLEGAL_CODE) ? RESIDUE_MAX : rawCode;

      // R4
      residue_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
        alignedCode[j] != ILLEGAL_CODE);
    end else begin : g_flash
      assign cleanCode[j] = rawCode;
    end

    corr_delay_line #(
      .DEPTH(alignDepth(j)),
      .W    (CODE_W)
    ) i_align (
      .clk    (clk),
      .rstN   (rstN),
      .shiftEn(strobes.shiftEn),
      .din    (cleanCode[j]),
      .dout   (alignedCode[j])
    );
  end

  // Overlapped addition: neighbouring stages share one bit of weight
  always_comb begin
    sumAcc = '0;
    for (int j = 0; j < NUM_STAGES; j++) begin
      sumAcc = sumAcc + (SUM_W'(alignedCode[j]) << stageShift(j));
    end
  end

  assign dataNext = (sumAcc > OUT_MAX) ? OUT_MAX[OUT_W-1:0] : sumAcc[OUT_W-1:0];

  // Output register on the falling edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
    end else if (strobes.outClear) begin
      dataOut <= '0;
    end else if (strobes.outLoad) begin
      dataOut <= dataNext;
    end
  end

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.outClear |-> (dataOut == '0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shiftEn |=> $stable(alignedCode[0]));

  // R10
  always @(posedge clk) begin
    if (!rstN) reset_data_chk: assert (dataOut == '0);
  end

endmodule

// File: rtl/pipe_adc_corr.sv
module pipe_adc_corr
  import adc_corr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             powerEn,
  input  logic [BUS_W-1:0] stageCodes,
  output logic [OUT_W-1:0] dataOut,
  output logic             dataValid
);

  corrStrobes_t strobes;

  corr_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .powerEn (powerEn),
    .strobes (strobes),
    .validOut(dataValid)
  );

  corr_datapath i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .stageCodes(stageCodes),
    .dataOut   (dataOut)
  );

endmodule

// File: tb/test_pipe_adc_corr.sv
module test_pipe_adc_corr;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  localparam int FULL = 4096;   // normalised input scale: x = level / FULL

  // Input levels and expected offset-binary words: floor((level+4096)/8)
  localparam int VEC_IN  [NVEC] = '{-4096, 4095, 0, -1, 8, -8, 1024, -1024,
                                     1023, 1025, 2000, -3000, 3333, -2222};
  localparam int VEC_EXP [NVEC] = '{0, 1023, 512, 511, 513, 511, 640, 384,
                                     639, 640, 762, 137, 928, 234};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        powerEn = 1'b0;
  logic [17:0] stageCodes = '0;
  logic [9:0]  dataOut;
  logic        dataValid;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  logic [17:0] sCodes [32];
  int          sExp   [32];

  pipe_adc_corr i_pipe_adc_corr (
    .clk       (clk),
    .rstN      (rstN),
    .powerEn   (powerEn),
    .stageCodes(stageCodes),
    .dataOut   (dataOut),
    .dataValid (dataValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // Behavioural 1.5-bit pipeline: decision levels at +/- FULL/4
  function automatic logic [17:0] quantize(int x);
    int r;
    int d9;
    logic [17:0] c;
    r = x;
    c = '0;
    for (int j = 0; j < 8; j++) begin
      if (r < -(FULL/4)) begin
        c[2*j +: 2] = 2'd0; r = 2*r + FULL;
      end else if (r > FULL/4) begin
        c[2*j +: 2] = 2'd2; r = 2*r - FULL;
      end else begin
        c[2*j +: 2] = 2'd1; r = 2*r;
      end
    end
    d9 = (r + FULL) >>> 11;
    if (d9 > 3) d9 = 3;
    if (d9 < 0) d9 = 0;
    c[17:16] = 2'(d9);
    return c;
  endfunction

  // Drive n samples with stage stagger, check each at exactly 5 cycles
  task automatic runStream(int n, string req);
    for (int k = 0; k < n + 5; k++) begin
      @(posedge clk); #1;
      for (int j = 0; j < 9; j++) begin
        int s;
        s = k - j/2;
        stageCodes[2*j +: 2] = (s >= 0 && s < n) ? sCodes[s][2*j +: 2] : 2'd0;
      end
      @(negedge clk); #1;
      if (k >= 5) check(req, int'(dataOut), sExp[k-5]);
    end
  endtask

  // Hold one code pattern on every stage long enough to fill all lines
  task automatic applyConst(logic [17:0] codes, int exp, string req);
    @(posedge clk); #1;
    stageCodes = codes;
    repeat (6) @(posedge clk);
    @(negedge clk); #1;
    check(req, int'(dataOut), exp);
  endtask

  // Count enabled edges, valid must rise exactly after the 20th
  task automatic warmUp(string req);
    @(posedge clk); #1;
    powerEn = 1'b1;
    for (int n = 1; n <= 20; n++) begin
      @(posedge clk);
      @(negedge clk); #1;
      if (n == 19) check({req, " valid before 20th"}, int'(dataValid), 0);
      if (n == 20) check({req, " valid at 20th"}, int'(dataValid), 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    #1;
    check("R10 data in reset", int'(dataOut), 0);
    check("R10 valid in reset", int'(dataValid), 0);
    @(posedge clk); #1;
    rstN = 1'b1;

    // R9: still powered down after reset
    repeat (3) @(negedge clk);
    #1;
    check("R9 data while down", int'(dataOut), 0);
    check("R9 valid while down", int'(dataValid), 0);

    // R8: warm-up count
    warmUp("R8");

    // R3: offset-binary anchors
    applyConst({2'd2, {8{2'd1}}}, 512, "R3 mid-scale");
    applyConst('0, 0, "R3 zero scale");
    applyConst({2'd3, {8{2'd2}}}, 1023, "R3 full scale");

    // R2: each residue weight on its own
    for (int j = 0; j < 8; j++) begin
      logic [17:0] c;
      c = '0;
      c[2*j +: 2] = 2'd1;
      applyConst(c, 1 << (8 - j), "R2 stage weight");
    end

    // R4: illegal residue code clamps to 2
    applyConst(18'h00003, 512, "R4 stage1 code 3");
    applyConst(18'h00030, 128, "R4 stage3 code 3");

    // R5: flash stage at weight 1, all values
    for (int v = 0; v < 4; v++) begin
      applyConst({2'(v), 16'h0000}, v, "R5 flash value");
    end

    // R6: everything at 3 saturates
    applyConst(18'h3FFFF, 1023, "R6 saturation");

    // R7 and R1: stream of levels through the stagger
    for (int s = 0; s < NVEC; s++) begin
      sCodes[s] = quantize(VEC_IN[s]);
      sExp[s]   = VEC_EXP[s];
    end
    runStream(NVEC, "R7 R1 stream");
    check("R1 valid during stream", int'(dataValid), 1);

    // R1: isolated full-scale sample pins the latency
    for (int s = 0; s < 5; s++) begin
      sCodes[s] = (s == 2) ? quantize(FULL - 1) : quantize(-FULL);
      sExp[s]   = (s == 2) ? 1023 : 0;
    end
    runStream(5, "R1 impulse");

    // R9: power-down clears output and valid at next falling edge
    @(posedge clk); #1;
    powerEn = 1'b0;
    @(posedge clk);
    @(negedge clk); #1;
    check("R9 valid after down", int'(dataValid), 0);
    check("R9 data after down", int'(dataOut), 0);

    // R9: count restarts from zero on re-enable
    warmUp("R9 restart");

    finishRun();
  end

endmodule